// File: doc/BRIEF.md
# Multi-Cycle Stack Processor Datapath

This block is the storage and steering part of a small 32-bit load/store processor with a stack. It holds the program counter, the instruction register, the stack pointer and a 32-entry register file. It also contains an ALU and the two-input selector chains that choose the ALU operands, the register write data and write address, the memory address, the store data and the next program counter. An external sequencer drives one packed 32-bit control word each cycle. Over several cycles, that word fetches, decodes, executes and retires an instruction.

The block does not decide anything by itself. Each multiplexer and each load enable follows one bit or field of the control word. The block reports the current instruction word and the ALU zero flag, so the sequencer can decode the instruction and resolve branches. Memory sits outside the block. The block presents an address and store data, and it takes back read data combinationally.

Top module: `mcDatapath`

## Requirements
- R1: A synchronous reset sets the program counter to 0, the instruction register to 0, every register to 0, the held read values to 0 and the stack pointer to the parameter `SP_TOP` (default 0x3FF).
- R2: On a rising edge with control bit 4 set, the instruction register takes `memRdData`. Otherwise it holds. `instrOut` always shows the instruction register.
- R3: The program counter changes only on a rising edge with control bit 0 set, and then takes the selected next address. The program counter counts in words.
- R4: Control bits 19:14 choose the ALU function. The codes are: 0x01 add, 0x02 subtract, 0x03 multiply (low 32 bits), 0x04 logical right shift, 0x05 left shift, 0x06 AND, 0x07 OR, 0x08 NOR, 0x09 signed set-less-than. Any other code yields 0. Shifts use the low 5 bits of operand B. `zeroFlag` is 1 exactly when the ALU result is 0.
- R5: Operand A is the stack pointer when bit 9 is set, otherwise register read data A. Read address A is the rs field (bits 25:21), but bit 5 forces it to register 0.
- R6: Operand B is chosen as follows. Read data B (read address rt, bits 20:16) when bit 13 is set. Otherwise, when bit 12 is set: the zero-extended shift amount (bits 10:6) if bit 10 is set, else the constant 1. Otherwise: the sign-extended 16-bit immediate if bit 11 is set, else the zero-extended immediate.
- R7: Register write data is chosen as follows. PC+1 when bit 25 is clear. Otherwise the immediate in the upper 16 bits with zeros below when bit 24 is set. Otherwise `memRdData` when bit 23 is set, else the ALU result.
- R8: A register is written on a rising edge with bit 7 set. The write address is rt (bit 26 set) or rd (bits 15:11, bit 26 clear) when bit 28 is set. When bit 28 is clear, it is register 31 if bit 27 is set, else register 0. Register 0 always reads 0, and writes to it are dropped.
- R9: The next PC is chosen as follows. The jump address {PC+1[31:26], instruction[25:0]} when bit 3 is clear. Otherwise the branch target PC+1+sign-extended immediate when bit 2 is set. Otherwise PC+1 when bit 1 is set, else read data A.
- R10: `memAddr` is the program counter when bit 21 is set. Otherwise it is the stack pointer when bit 20 is set, else the ALU result.
- R11: `memWrData` is read data A when bit 22 is set, otherwise read data B.
- R12: The stack pointer takes the ALU result on a rising edge with bit 8 set, and holds otherwise.
- R13: While bit 6 is set, read data A and B come live from the register file. At each rising edge with bit 6 set, both values are captured. While bit 6 is clear, the captured values are presented, even if registers are written in the meantime.
- R14: Control bits 31:29 have no effect on any output or state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ctrlWord | input | 32 | Packed control word from the sequencer |
| memRdData | input | 32 | Data read from memory at `memAddr` |
| zeroFlag | output | 1 | ALU result is zero |
| instrOut | output | 32 | Current instruction register contents |
| memAddr | output | 32 | Word address presented to memory |
| memWrData | output | 32 | Data offered to memory for a store or push |

## Verification
The embedded assertions check these properties on every cycle:
- the program counter and stack pointer hold when their load bits are clear;
- the instruction register captures memory data;
- a register write lands in storage and register 0 reads zero;
- the held read values stay frozen while the read bit is clear;
- a plain sequential step adds exactly one to the program counter;
- subtracting equal operands raises the zero flag.

Only the bench scenarios can show that every stage of the operand, write-data, write-address and next-PC chains picks the right source. The same holds for the branch and jump target arithmetic, the ALU results for each function code, and the claim that the three spare control bits change nothing.

// File: rtl/mcDpPkg.sv
package mcDpPkg;

  // instruction field geometry (fixed by the instruction format)
  localparam int REG_AW   = 5;
  localparam int REG_COUNT = 1 << REG_AW;
  localparam int IMM_W    = 16;
  localparam int JADDR_W  = 26;
  localparam int SHAMT_W  = 5;
  localparam int RS_LSB   = 21;
  localparam int RT_LSB   = 16;
  localparam int RD_LSB   = 11;
  localparam int SH_LSB   = 6;
  localparam int ALUOP_W  = 6;

  // ALU function codes
  localparam logic [ALUOP_W-1:0] ALU_ADD = 6'h01;
  localparam logic [ALUOP_W-1:0] ALU_SUB = 6'h02;
  localparam logic [ALUOP_W-1:0] ALU_MUL = 6'h03;
  localparam logic [ALUOP_W-1:0] ALU_SRL = 6'h04;
  localparam logic [ALUOP_W-1:0] ALU_SLL = 6'h05;
  localparam logic [ALUOP_W-1:0] ALU_AND = 6'h06;
  localparam logic [ALUOP_W-1:0] ALU_OR  = 6'h07;
  localparam logic [ALUOP_W-1:0] ALU_NOR = 6'h08;
  localparam logic [ALUOP_W-1:0] ALU_SLT = 6'h09;

  // strobes handed from the control-word unpacker to the datapath
  typedef struct packed {
    logic                 pcLoad;
    logic                 pcSelSeq;     // 1: PC+1, 0: register jump
    logic                 pcSelBranch;  // 1: branch target
    logic                 pcSelChain;   // 0: absolute jump
    logic                 irLoad;
    logic                 rdAForceZero;
    logic                 regRead;
    logic                 regWrite;
    logic                 spLoad;
    logic                 opASp;
    logic                 opBShamt;
    logic                 opBSext;
    logic                 opBSmall;
    logic                 opBReg;
    logic [ALUOP_W-1:0]   aluOp;
    logic                 maSp;
    logic                 maPc;
    logic                 mdSelA;
    logic                 wdMem;
    logic                 wdUpper;
    logic                 wdSelChain;   // 0: link value PC+1
    logic                 waField;
    logic                 waLink;
    logic                 waSelField;
  } dpStrobes_t;

endpackage

// File: rtl/mcCtrlUnpack.sv
module mcCtrlUnpack
  import mcDpPkg::*;
#(
  parameter int CW_W = 32
) (
  input  logic [CW_W-1:0] ctrlWord,
  output dpStrobes_t      str
);

  // bits above 28 carry nothing for this datapath
  logic unusedSpareBits;
  assign unusedSpareBits = ^ctrlWord[CW_W-1:29];

  always_comb begin
    str.pcLoad       = ctrlWord[0];
    str.pcSelSeq     = ctrlWord[1];
    str.pcSelBranch  = ctrlWord[2];
    str.pcSelChain   = ctrlWord[3];
    str.irLoad       = ctrlWord[4];
    str.rdAForceZero = ctrlWord[5];
    str.regRead      = ctrlWord[6];
    str.regWrite     = ctrlWord[7];
    str.spLoad       = ctrlWord[8];
    str.opASp        = ctrlWord[9];
    str.opBShamt     = ctrlWord[10];
    str.opBSext      = ctrlWord[11];
    str.opBSmall     = ctrlWord[12];
    str.opBReg       = ctrlWord[13];
    str.aluOp        = ctrlWord[19:14];
    str.maSp         = ctrlWord[20];
    str.maPc         = ctrlWord[21];
    str.mdSelA       = ctrlWord[22];
    str.wdMem        = ctrlWord[23];
    str.wdUpper      = ctrlWord[24];
    str.wdSelChain   = ctrlWord[25];
    str.waField      = ctrlWord[26];
    str.waLink       = ctrlWord[27];
    str.waSelField   = ctrlWord[28];
  end

endmodule

// File: rtl/mcAlu.sv
module mcAlu
  import mcDpPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [ALUOP_W-1:0] op,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  output logic [DATA_W-1:0]  y,
  output logic               zero
);

  localparam int SHW = $clog2(DATA_W);

  logic [SHW-1:0] shAmt;
  assign shAmt = b[SHW-1:0];

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_MUL: y = a * b;
      ALU_SRL: y = a >> shAmt;
      ALU_SLL: y = a << shAmt;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SLT: y = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mcRegFile.sv
module mcRegFile #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int RD_PORTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr [RD_PORTS],
  output logic [DATA_W-1:0] rdData [RD_PORTS],
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regQ [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regQ[i] <= '0;
    end else if (wrEn && wrAddr != '0) begin
      regQ[wrAddr] <= wrData;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : gRdPort
    logic [DATA_W-1:0] liveVal;
    logic [DATA_W-1:0] holdQ;

    assign liveVal = (rdAddr[p] == '0) ? '0 : regQ[rdAddr[p]];

    always_ff @(posedge clk) begin
      if (rst)       holdQ <= '0;
      else if (rdEn) holdQ <= liveVal;
    end

    assign rdData[p] = rdEn ? liveVal : holdQ;

    // R13
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!rdEn && $past(!rst)) |-> rdData[p] == $past(rdData[p]));

    // R8
    r0_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rdEn && rdAddr[p] == '0) |-> rdData[p] == '0);
  end

  // R8
  wr_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != '0) |=> regQ[$past(wrAddr)] == $past(wrData));

endmodule

// File: rtl/mcDpCore.sv
module mcDpCore
  import mcDpPkg::*;
#(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] SP_TOP = 'h3FF
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobes_t        str,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] instr,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              zeroFlag
);

  localparam logic [REG_AW-1:0] LINK_REG = REG_AW'(REG_COUNT - 1);
  localparam int                HI_W     = DATA_W - JADDR_W;

  logic [DATA_W-1:0] pcQ, irQ, spQ;

  // instruction fields
  logic [REG_AW-1:0]  rsF, rtF, rdF;
  logic [SHAMT_W-1:0] shF;
  logic [IMM_W-1:0]   immF;
  logic [JADDR_W-1:0] jF;

  assign rsF  = irQ[RS_LSB +: REG_AW];
  assign rtF  = irQ[RT_LSB +: REG_AW];
  assign rdF  = irQ[RD_LSB +: REG_AW];
  assign shF  = irQ[SH_LSB +: SHAMT_W];
  assign immF = irQ[IMM_W-1:0];
  assign jF   = irQ[JADDR_W-1:0];

  logic [DATA_W-1:0] immSext, immZext, immUpper, shamtExt;
  assign immSext  = {{(DATA_W-IMM_W){immF[IMM_W-1]}}, immF};
  assign immZext  = {{(DATA_W-IMM_W){1'b0}}, immF};
  assign immUpper = {immF, {(DATA_W-IMM_W){1'b0}}};
  assign shamtExt = {{(DATA_W-SHAMT_W){1'b0}}, shF};

  // register file
  logic [REG_AW-1:0] rfAddr [2];
  logic [DATA_W-1:0] rfData [2];
  logic [REG_AW-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdA, rdB;

  assign rfAddr[0] = str.rdAForceZero ? '0 : rsF;
  assign rfAddr[1] = rtF;
  assign rdA = rfData[0];
  assign rdB = rfData[1];

  mcRegFile #(
    .DATA_W  (DATA_W),
    .ADDR_W  (REG_AW),
    .RD_PORTS(2)
  ) regFile_i (
    .clk   (clk),
    .rst   (rst),
    .rdEn  (str.regRead),
    .rdAddr(rfAddr),
    .rdData(rfData),
    .wrEn  (str.regWrite),
    .wrAddr(wrAddr),
    .wrData(wrData)
  );

  // operand selection
  logic [DATA_W-1:0] opA, opB1, opB2, opB3, opB, aluY;

  assign opA  = str.opASp    ? spQ      : rdA;
  assign opB1 = str.opBShamt ? shamtExt : DATA_W'(1);
  assign opB2 = str.opBSext  ? immSext  : immZext;
  assign opB3 = str.opBSmall ? opB1     : opB2;
  assign opB  = str.opBReg   ? rdB      : opB3;

  mcAlu #(.DATA_W(DATA_W)) alu_i (
    .op  (str.aluOp),
    .a   (opA),
    .b   (opB),
    .y   (aluY),
    .zero(zeroFlag)
  );

  // write-back selection
  logic [DATA_W-1:0] pcInc, wd1, wd2;
  logic [REG_AW-1:0] wa1, wa2;

  assign pcInc  = pcQ + DATA_W'(1);
  assign wd1    = str.wdMem      ? memRdData : aluY;
  assign wd2    = str.wdUpper    ? immUpper  : wd1;
  assign wrData = str.wdSelChain ? wd2       : pcInc;

  assign wa1    = str.waField    ? rtF       : rdF;
  assign wa2    = str.waLink     ? LINK_REG  : '0;
  assign wrAddr = str.waSelField ? wa1       : wa2;

  // next program counter
  logic [DATA_W-1:0] brTarget, jmpTarget, np1, np2, pcNext;

  assign brTarget  = pcInc + immSext;
  assign jmpTarget = {pcInc[DATA_W-1 -: HI_W], jF};
  assign np1       = str.pcSelSeq    ? pcInc    : rdA;
  assign np2       = str.pcSelBranch ? brTarget : np1;
  assign pcNext    = str.pcSelChain  ? np2      : jmpTarget;

  // architectural registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ <= '0;
      irQ <= '0;
      spQ <= SP_TOP;
    end else begin
      if (str.pcLoad) pcQ <= pcNext;
      if (str.irLoad) irQ <= memRdData;
      if (str.spLoad) spQ <= aluY;
    end
  end

  // memory side
  assign memAddr   = str.maPc   ? pcQ : (str.maSp ? spQ : aluY);
  assign memWrData = str.mdSelA ? rdA : rdB;
  assign instr     = irQ;

  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !str.pcLoad |=> $stable(pcQ));

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (str.pcLoad && str.pcSelSeq && !str.pcSelBranch && str.pcSelChain)
      |=> pcQ == $past(pcQ) + DATA_W'(1));

  // R2
  ir_capture_chk: assert property (@(posedge clk) disable iff (rst)
    str.irLoad |=> irQ == $past(memRdData));

  // R12
  sp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !str.spLoad |=> $stable(spQ));

  // R4
  sub_equal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (str.aluOp == ALU_SUB && opA == opB) |-> zeroFlag);

endmodule

// File: rtl/mcDatapath.sv
module mcDatapath
  import mcDpPkg::*;
#(
  parameter int                DATA_W = 32,
  parameter int                CW_W   = 32,
  parameter logic [DATA_W-1:0] SP_TOP = 'h3FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   ctrlWord,
  input  logic [DATA_W-1:0] memRdData,
  output logic              zeroFlag,
  output logic [DATA_W-1:0] instrOut,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData
);

  dpStrobes_t str;

  mcCtrlUnpack #(.CW_W(CW_W)) unpack_i (
    .ctrlWord(ctrlWord),
    .str     (str)
  );

  mcDpCore #(
    .DATA_W(DATA_W),
    .SP_TOP(SP_TOP)
  ) core_i (
    .clk      (clk),
    .rst      (rst),
    .str      (str),
    .memRdData(memRdData),
    .instr    (instrOut),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .zeroFlag (zeroFlag)
  );

endmodule

// File: tb/mcDatapath_tb_top.sv
module mcDatapath_tb_top;

  localparam logic [31:0] SP_TOP_TB = 32'h0000_03FF;

  // control bits
  localparam logic [31:0] PCLD = 32'd1 << 0;
  localparam logic [31:0] PCS1 = 32'd1 << 1;
  localparam logic [31:0] PCS2 = 32'd1 << 2;
  localparam logic [31:0] PCS3 = 32'd1 << 3;
  localparam logic [31:0] IRLD = 32'd1 << 4;
  localparam logic [31:0] R1Z  = 32'd1 << 5;
  localparam logic [31:0] REGR = 32'd1 << 6;
  localparam logic [31:0] REGW = 32'd1 << 7;
  localparam logic [31:0] SPLD = 32'd1 << 8;
  localparam logic [31:0] OPAS = 32'd1 << 9;
  localparam logic [31:0] OB1  = 32'd1 << 10;
  localparam logic [31:0] OB2  = 32'd1 << 11;
  localparam logic [31:0] OB3  = 32'd1 << 12;
  localparam logic [31:0] OB4  = 32'd1 << 13;
  localparam logic [31:0] MA1  = 32'd1 << 20;
  localparam logic [31:0] MA2  = 32'd1 << 21;
  localparam logic [31:0] MDS  = 32'd1 << 22;
  localparam logic [31:0] WD1  = 32'd1 << 23;
  localparam logic [31:0] WD2  = 32'd1 << 24;
  localparam logic [31:0] WD3  = 32'd1 << 25;
  localparam logic [31:0] WA1  = 32'd1 << 26;
  localparam logic [31:0] WA2  = 32'd1 << 27;
  localparam logic [31:0] WA3  = 32'd1 << 28;
  localparam logic [31:0] SPARE = 32'hE000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctrlWord = '0;
  logic [31:0] memRdData;
  logic        zeroFlag;
  logic [31:0] instrOut, memAddr, memWrData;

  logic [31:0] benchMem [256];
  assign memRdData = benchMem[memAddr[7:0]];

  always #2 clk = ~clk;

  mcDatapath #(.SP_TOP(SP_TOP_TB)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .ctrlWord (ctrlWord),
    .memRdData(memRdData),
    .zeroFlag (zeroFlag),
    .instrOut (instrOut),
    .memAddr  (memAddr),
    .memWrData(memWrData)
  );

  // reference state
  logic [31:0] mPc, mIr, mSp, mHoldA, mHoldB;
  logic [31:0] mRegs [32];

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  function automatic logic [31:0] opc(input int op);
    return 32'(op) << 14;
  endfunction

  function automatic logic [31:0] refAlu(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    r = 32'h0;
    if (op == 6'h01) r = a + b;
    else if (op == 6'h02) r = a - b;
    else if (op == 6'h03) r = a * b;
    else if (op == 6'h04) r = a >> b[4:0];
    else if (op == 6'h05) r = a << b[4:0];
    else if (op == 6'h06) r = a & b;
    else if (op == 6'h07) r = a | b;
    else if (op == 6'h08) r = ~(a | b);
    else if (op == 6'h09) r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    return r;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] cw, input string tag);
    logic [4:0]  rsI, rtI, rdI, waI;
    logic [31:0] liveA, liveB, a, b, opA, opB, alu, sext, zext, shx;
    logic [31:0] eAddr, eWr, wData, pcInc, nPc, rdVal;
    @(negedge clk);
    ctrlWord = cw;
    #1;
    rsI  = mIr[25:21];
    rtI  = mIr[20:16];
    rdI  = mIr[15:11];
    sext = {{16{mIr[15]}}, mIr[15:0]};
    zext = {16'h0, mIr[15:0]};
    shx  = {27'h0, mIr[10:6]};
    liveA = mRegs[cw[5] ? 5'd0 : rsI];
    liveB = mRegs[rtI];
    a = cw[6] ? liveA : mHoldA;
    b = cw[6] ? liveB : mHoldB;
    opA = cw[9] ? mSp : a;
    if (cw[13])      opB = b;
    else if (cw[12]) opB = cw[10] ? shx : 32'd1;
    else             opB = cw[11] ? sext : zext;
    alu = refAlu(cw[19:14], opA, opB);
    if (cw[21])      eAddr = mPc;
    else if (cw[20]) eAddr = mSp;
    else             eAddr = alu;
    eWr = cw[22] ? a : b;
    rdVal = benchMem[eAddr[7:0]];
    pcInc = mPc + 32'd1;
    if (!cw[25])     wData = pcInc;
    else if (cw[24]) wData = {mIr[15:0], 16'h0};
    else if (cw[23]) wData = rdVal;
    else             wData = alu;
    if (cw[28]) waI = cw[26] ? rtI : rdI;
    else        waI = cw[27] ? 5'd31 : 5'd0;
    if (!cw[3])     nPc = {pcInc[31:26], mIr[25:0]};
    else if (cw[2]) nPc = pcInc + sext;
    else if (cw[1]) nPc = pcInc;
    else            nPc = a;
    cmp(tag, "instrOut", instrOut, mIr);
    cmp(tag, "memAddr", memAddr, eAddr);
    cmp(tag, "memWrData", memWrData, eWr);
    cmp(tag, "zeroFlag", {31'h0, zeroFlag}, {31'h0, alu == 32'h0});
    @(posedge clk);
    if (cw[0]) mPc = nPc;
    if (cw[4]) mIr = rdVal;
    if (cw[8]) mSp = alu;
    if (cw[6]) begin
      mHoldA = liveA;
      mHoldB = liveB;
    end
    if (cw[7] && waI != 5'd0) mRegs[waI] = wData;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) benchMem[i] = 32'(i) * 32'h0101_0103 + 32'h1357_9BDF;
    benchMem[0] = {6'h00, 5'd3, 5'd4, 5'd5, 5'd2, 6'h20};
    benchMem[1] = {6'h08, 5'd4, 5'd3, 16'hFFF0};
    benchMem[2] = {6'h0c, 5'd3, 5'd6, 16'h8001};
    mPc = '0; mIr = '0; mSp = SP_TOP_TB; mHoldA = '0; mHoldB = '0;
    for (int i = 0; i < 32; i++) mRegs[i] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // reset state
    step(0, "R1");
    step(MA2, "R1");
    step(MA1, "R1");
    // instruction register
    step(MA2 | IRLD, "R2");
    step(MA2, "R2");
    step(SPARE | MA2, "R14");
    step(SPARE | MA1 | OPAS | OB3 | opc(1), "R14");
    // fill registers from IR = mem[0]: rs 3, rt 4, rd 5
    step(MA1 | WD1 | WD3 | WA1 | WA3 | REGW, "R7");
    step(WA3 | REGW, "R7");
    step(WA2 | WD2 | WD3 | REGW, "R8");
    step(MA1 | WD1 | WD3 | REGW, "R8");
    step(REGR | R1Z | MDS, "R8");
    step(MA2 | WD1 | WD3 | WA3 | REGW, "R7");
    // advance and fetch mem[1]: rs 4, rt 3
    step(PCLD | PCS1 | PCS3, "R9");
    step(MA2 | IRLD, "R2");
    step(REGR | OB2 | opc(1) | WD3 | WA1 | WA3 | REGW, "R6");
    // held reads
    step(REGR, "R13");
    step(MDS, "R13");
    step(WD2 | WD3 | WA1 | WA3 | REGW, "R13");
    step(0, "R13");
    step(MDS, "R13");
    step(REGR, "R13");
    step(REGR | MDS, "R11");
    step(REGR, "R11");
    // ALU function sweep, two operand patterns
    for (int op = 0; op < 11; op++) step(REGR | OB4 | opc(op), "R4");
    for (int op = 0; op < 11; op++) step(REGR | OB3 | OB1 | opc(op), "R4");
    step(REGR | R1Z | OB4 | opc(6), "R4");
    step(REGR | R1Z | R1Z | opc(2), "R4");
    // operand A
    step(OPAS | OB3 | opc(1), "R5");
    step(REGR | R1Z | OB4 | opc(1), "R5");
    step(REGR | opc(1), "R5");
    // operand B chain
    step(REGR | R1Z | opc(1), "R6");
    step(REGR | R1Z | OB2 | opc(1), "R6");
    step(REGR | R1Z | OB3 | opc(1), "R6");
    step(REGR | R1Z | OB3 | OB1 | opc(1), "R6");
    step(REGR | R1Z | OB4 | opc(1), "R6");
    step(REGR | R1Z | OB4 | OB3 | OB1 | OB2 | opc(1), "R6");
    // stack pointer
    step(OPAS | OB3 | opc(2) | SPLD, "R12");
    step(MA1, "R12");
    step(OPAS | OB3 | opc(1) | SPLD | MA1, "R12");
    step(MA1, "R12");
    step(OPAS | OB3 | opc(1) | MA1, "R12");
    step(MA1, "R12");
    // program counter hold and step
    step(PCS1 | PCS3, "R3");
    step(MA2, "R3");
    step(PCLD | PCS1 | PCS3, "R3");
    step(MA2, "R3");
    // branch, register jump, absolute jump
    step(PCLD | PCS1 | PCS2 | PCS3, "R9");
    step(MA2, "R9");
    step(REGR | PCLD | PCS3, "R9");
    step(MA2, "R9");
    step(PCLD, "R9");
    step(MA2 | IRLD, "R9");
    step(WA2 | REGW, "R7");
    step(REGR | MDS, "R8");
    // memory address priority
    step(MA1 | MA2, "R10");
    step(REGR | OB4 | opc(1), "R10");
    for (int op = 1; op < 10; op++) step(REGR | OB2 | opc(op), "R4");
    step(SPARE | PCS1 | PCS3, "R14");
    step(MA2, "R14");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

endmodule